// File: doc/BRIEF.md
# Self-Triggering Hit Finder with Circular Sample Store

This block takes one stream of 10-bit samples that carries sixteen wire channels in strict rotation, one sample per valid cycle. Each channel's samples pass through a three-point median filter that removes single-sample noise spikes. The filtered value is then compared with a programmable threshold. A channel whose filtered value rises above the threshold raises a self-trigger pulse, with no trigger input from outside the block.

Only samples near a hit are kept. These are the samples from a fixed number of frames before the hit up to a programmable number of frames after the last above-threshold sample. Each kept sample is written into a circular store that the block manages itself. Every record carries the channel number, the filtered value and the 28-bit number of the frame in which the sample arrived, so that data from many instances can later be aligned in time. A consumer drains the store through a simple read strobe. When the store is full, new records are dropped and a sticky overflow flag is set.

Each channel has a tracking state machine with three states. QUIET means no hit is in progress and nothing is stored. ABOVE means the current filtered sample is over the threshold. TRAIL means the channel is counting frames since its last hit. The transitions are:
- start: QUIET to ABOVE, when the filtered sample is over the threshold.
- retrigger: TRAIL to ABOVE, or ABOVE to ABOVE, on any sample over the threshold.
- fall: ABOVE to TRAIL, on the first sample at or below the threshold.
- expire: TRAIL to QUIET, or ABOVE to QUIET when the window is zero, once the frames since the last hit exceed the window. The window is the pre-trigger depth plus the post-sample count.

Top module: `hit_finder_ring`

## Requirements
- R1: After reset the first valid sample belongs to channel 0. Each further valid sample belongs to the next channel, wrapping from 15 to 0. Cycles with in_valid low change nothing. Each stored record carries its channel in rd_ch.
- R2: The filtered value of a sample is the median of that sample and the two previous samples of the same channel. The history reads as zero after reset. A lone spike between two quiet samples therefore gives no hit.
- R3: A sample is a hit when its filtered value is strictly greater than cfg_thresh. A filtered value equal to the threshold is not a hit.
- R4: A hit on a channel that is not in ABOVE gives trig high for exactly one cycle, in the cycle after that sample is accepted. In the same cycle trig_ch gives the channel. Further hits while the channel stays in ABOVE give no new pulse.
- R5: The stored value for a channel is its filtered value from PRE frames earlier (PRE defaults to 2), so the PRE frames before a hit are kept.
- R6: A filtered sample from frame f is stored when that channel has a hit in some frame h with f ≤ h+cfg_post and h ≤ f+PRE.
- R7: Every sample outside such a window is dropped. While no hit occurs, buf_empty stays high.
- R8: A frame counter starts at 0 after reset and advances after the valid sample of channel 15. It is 28 bits wide and wraps at 2^28. rd_stamp is the number of the frame in which the stored sample arrived.
- R9: Records are read back in write order. rd_en while the store is not empty gives rd_valid high with the record in the next cycle. rd_en while buf_empty is high gives no rd_valid.
- R10: A record that would be written while the store holds DEPTH records is discarded, and the store keeps its contents. overflow then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present on in_sample |
| in_sample | input | 10 | Raw sample of the current channel |
| cfg_thresh | input | 10 | Hit threshold for filtered values |
| cfg_post | input | POST_W | Frames kept after the last hit |
| rd_en | input | 1 | Read strobe for the store |
| rd_valid | output | 1 | Read record is present |
| rd_ch | output | 4 | Channel of the read record |
| rd_value | output | 10 | Filtered value of the read record |
| rd_stamp | output | 28 | Frame number of the read record |
| buf_empty | output | 1 | The store holds no records |
| overflow | output | 1 | Sticky: a record was dropped because the store was full |
| trig | output | 1 | Self-trigger pulse |
| trig_ch | output | 4 | Channel that caused trig |

## Verification
The assertions check, on every cycle, the parts of the behaviour that are local in time. These are the channel rotation and its hold on idle cycles, the frame counter step, the cause of a trigger pulse, the one-cycle read latency and the empty-read rule, and the cause and persistence of overflow. The median value, the threshold comparison, the length of the kept window and the delayed timestamps depend on a history several frames long. Only the bench's scenarios can show these, by comparing each drained record against a reference model. The same holds for the drop-when-full order, seen in which records survive an overflow.

// File: rtl/hf_pkg.sv
package hf_pkg;
    localparam int CH_N  = 16;
    localparam int CH_W  = $clog2(CH_N);
    localparam int SMP_W = 10;
    localparam int TS_W  = 28;

    typedef enum logic [1:0] {
        CH_QUIET = 2'd0,
        CH_ABOVE = 2'd1,
        CH_TRAIL = 2'd2
    } chan_state_t;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [SMP_W-1:0] value;
        logic [TS_W-1:0]  stamp;
    } rec_t;
endpackage

// File: rtl/hf_median3.sv
module hf_median3 #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] m
);
    logic [W-1:0] lo_ab;
    logic [W-1:0] hi_ab;
    logic [W-1:0] lo_hc;

    always_comb begin
        lo_ab = (a < b) ? a : b;
        hi_ab = (a < b) ? b : a;
        lo_hc = (hi_ab < c) ? hi_ab : c;
        m     = (lo_ab > lo_hc) ? lo_ab : lo_hc;
    end
endmodule

// File: rtl/hf_chan_fsm.sv
module hf_chan_fsm
    import hf_pkg::*;
#(
    parameter int PRE    = 2,
    parameter int POST_W = 4,
    localparam int WIN_W = $clog2(PRE + (1 << POST_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [SMP_W-1:0]  in_sample,
    input  logic [SMP_W-1:0]  thr,
    input  logic [POST_W-1:0] post,
    output logic              fire,
    output logic              keep,
    output logic [SMP_W-1:0]  keep_value
);
    logic [SMP_W-1:0] hist1 [CH_N];
    logic [SMP_W-1:0] hist2 [CH_N];
    chan_state_t      st    [CH_N];
    logic [WIN_W-1:0] age   [CH_N];

    logic [SMP_W-1:0] med;
    logic             is_hit;
    logic [WIN_W-1:0] window;
    chan_state_t      cur_st;
    chan_state_t      nxt_st;
    logic [WIN_W-1:0] cur_age;
    logic [WIN_W-1:0] nxt_age;

    hf_median3 #(.W(SMP_W)) u_med (
        .a (in_sample),
        .b (hist1[in_ch]),
        .c (hist2[in_ch]),
        .m (med)
    );

    // Next state and outputs
    always_comb begin
        is_hit  = (med > thr);
        window  = WIN_W'(PRE) + WIN_W'(post);
        cur_st  = st[in_ch];
        cur_age = age[in_ch];
        nxt_st  = cur_st;
        nxt_age = cur_age;
        unique case (cur_st)
            CH_QUIET: begin
                if (is_hit) begin
                    nxt_st  = CH_ABOVE;
                    nxt_age = '0;
                end
            end
            CH_ABOVE: begin
                if (is_hit) begin
                    nxt_st  = CH_ABOVE;
                    nxt_age = '0;
                end else if (window == '0) begin
                    nxt_st  = CH_QUIET;
                    nxt_age = '0;
                end else begin
                    nxt_st  = CH_TRAIL;
                    nxt_age = WIN_W'(1);
                end
            end
            CH_TRAIL: begin
                if (is_hit) begin
                    nxt_st  = CH_ABOVE;
                    nxt_age = '0;
                end else if (cur_age >= window) begin
                    nxt_st  = CH_QUIET;
                    nxt_age = '0;
                end else begin
                    nxt_st  = CH_TRAIL;
                    nxt_age = cur_age + WIN_W'(1);
                end
            end
            default: begin
                nxt_st  = CH_QUIET;
                nxt_age = '0;
            end
        endcase
        fire = in_valid && is_hit && (cur_st != CH_ABOVE);
        keep = in_valid && (nxt_st != CH_QUIET);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH_N; i++) begin
                hist1[i] <= '0;
                hist2[i] <= '0;
                st[i]    <= CH_QUIET;
                age[i]   <= '0;
            end
        end else if (in_valid) begin
            hist1[in_ch] <= in_sample;
            hist2[in_ch] <= hist1[in_ch];
            st[in_ch]    <= nxt_st;
            age[in_ch]   <= nxt_age;
        end
    end

    generate
        if (PRE > 0) begin : g_pre
            logic [SMP_W-1:0] dly [CH_N][PRE];
            assign keep_value = dly[in_ch][PRE-1];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < CH_N; i++)
                        for (int j = 0; j < PRE; j++)
                            dly[i][j] <= '0;
                end else if (in_valid) begin
                    dly[in_ch][0] <= med;
                    for (int j = 1; j < PRE; j++)
                        dly[in_ch][j] <= dly[in_ch][j-1];
                end
            end
        end else begin : g_nopre
            assign keep_value = med;
        end
    endgenerate
endmodule

// File: rtl/hf_ring.sv
module hf_ring
    import hf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  rec_t wr_data,
    input  logic rd_en,
    output rec_t rd_data,
    output logic rd_valid,
    output logic empty,
    output logic full,
    output logic overflow
);
    rec_t        mem [DEPTH];
    logic [AW:0] wp;
    logic [AW:0] rp;

    always_comb begin
        empty = (wp == rp);
        full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full)
            mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            overflow <= 1'b0;
        end else begin
            rd_valid <= rd_en && !empty;
            if (wr_en && !full)
                wp <= wp + 1'b1;
            if (wr_en && full)
                overflow <= 1'b1;
            if (rd_en && !empty) begin
                rd_data <= mem[rp[AW-1:0]];
                rp      <= rp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hit_finder_ring.sv
module hit_finder_ring
    import hf_pkg::*;
#(
    parameter int PRE    = 2,
    parameter int POST_W = 4,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [9:0]        in_sample,
    input  logic [9:0]        cfg_thresh,
    input  logic [POST_W-1:0] cfg_post,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [3:0]        rd_ch,
    output logic [9:0]        rd_value,
    output logic [27:0]       rd_stamp,
    output logic              buf_empty,
    output logic              overflow,
    output logic              trig,
    output logic [3:0]        trig_ch
);
    logic [CH_W-1:0]  ch_q;
    logic [TS_W-1:0]  ts_q;
    logic             fire;
    logic             keep;
    logic [SMP_W-1:0] keep_value;
    logic             ring_full;
    rec_t             wr_rec;
    rec_t             rd_rec;

    hf_chan_fsm #(.PRE(PRE), .POST_W(POST_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ch      (ch_q),
        .in_sample  (in_sample),
        .thr        (cfg_thresh),
        .post       (cfg_post),
        .fire       (fire),
        .keep       (keep),
        .keep_value (keep_value)
    );

    always_comb begin
        wr_rec.ch    = ch_q;
        wr_rec.value = keep_value;
        wr_rec.stamp = ts_q - TS_W'(PRE);
    end

    hf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (keep),
        .wr_data  (wr_rec),
        .rd_en    (rd_en),
        .rd_data  (rd_rec),
        .rd_valid (rd_valid),
        .empty    (buf_empty),
        .full     (ring_full),
        .overflow (overflow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q    <= '0;
            ts_q    <= '0;
            trig    <= 1'b0;
            trig_ch <= '0;
        end else begin
            trig <= fire;
            if (fire)
                trig_ch <= ch_q;
            if (in_valid) begin
                if (ch_q == CH_W'(CH_N - 1)) begin
                    ch_q <= '0;
                    ts_q <= ts_q + 1'b1;
                end else begin
                    ch_q <= ch_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_ch    = rd_rec.ch;
        rd_value = rd_rec.value;
        rd_stamp = rd_rec.stamp;
    end
endmodule

// File: rtl/hf_checker.sv
module hf_checker
    import hf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CH_W-1:0] ch_q,
    input logic [TS_W-1:0] ts_q,
    input logic            trig,
    input logic            rd_en,
    input logic            buf_empty,
    input logic            rd_valid,
    input logic            overflow,
    input logic            wr_en,
    input logic            full
);
    a_r1_chan_advance: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ch_q == CH_W'($past(ch_q) + 1'b1)));
    a_r1_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ch_q));
    a_r8_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ch_q == CH_W'(CH_N - 1)) |=> (ts_q == $past(ts_q) + 1'b1));
    a_r8_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && ch_q == CH_W'(CH_N - 1)) |=> $stable(ts_q));
    a_r4_trig_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(in_valid));
    a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !buf_empty) |=> rd_valid);
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && buf_empty) |=> !rd_valid);
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r10_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_en && full));
endmodule

bind hit_finder_ring hf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ch_q      (ch_q),
    .ts_q      (ts_q),
    .trig      (trig),
    .rd_en     (rd_en),
    .buf_empty (buf_empty),
    .rd_valid  (rd_valid),
    .overflow  (overflow),
    .wr_en     (keep),
    .full      (ring_full)
);

// File: tb/tb_hit_finder_ring.sv
module tb_hit_finder_ring;
    localparam int PRE    = 2;
    localparam int POST_W = 4;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [9:0]        in_sample = '0;
    logic [9:0]        cfg_thresh = 10'd500;
    logic [POST_W-1:0] cfg_post = '0;
    logic              rd_en = 1'b0;
    logic              rd_valid;
    logic [3:0]        rd_ch;
    logic [9:0]        rd_value;
    logic [27:0]       rd_stamp;
    logic              buf_empty;
    logic              overflow;
    logic              trig;
    logic [3:0]        trig_ch;

    always #2 clk = ~clk;

    hit_finder_ring #(.PRE(PRE), .POST_W(POST_W), .DEPTH(DEPTH)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_h1[16], m_h2[16], m_dly[16][PRE], m_st[16], m_age[16];
    int m_ch = 0, m_ts = 0, m_occ = 0;
    bit m_ovf = 0, e_trig = 0;
    int e_tch = 0;
    int q_ch[$], q_val[$], q_ts[$];
    bit e_rd = 0;
    int e_rch = 0, e_rval = 0, e_rts = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int med3(input int a, input int b, input int c);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        int x  = (hi < c) ? hi : c;
        return (lo > x) ? lo : x;
    endfunction

    task automatic model_step(input int s);
        int ch = m_ch;
        int md = med3(s, m_h1[ch], m_h2[ch]);
        bit hit = md > int'(cfg_thresh);
        int old = m_dly[ch][PRE-1];
        int win = PRE + int'(cfg_post);
        int ns;
        for (int j = PRE - 1; j > 0; j--) m_dly[ch][j] = m_dly[ch][j-1];
        m_dly[ch][0] = md;
        m_h2[ch] = m_h1[ch];
        m_h1[ch] = s;
        e_trig = hit && (m_st[ch] != 1);
        if (e_trig) e_tch = ch;
        if (hit) begin ns = 1; m_age[ch] = 0; end
        else if (m_st[ch] == 0) ns = 0;
        else begin
            m_age[ch] = (m_st[ch] == 1) ? 1 : m_age[ch] + 1;
            ns = (m_age[ch] > win) ? 0 : 2;
        end
        m_st[ch] = ns;
        if (ns != 0) begin
            if (m_occ < DEPTH) begin
                q_ch.push_back(ch); q_val.push_back(old);
                q_ts.push_back((m_ts - PRE) & 32'h0FFF_FFFF);
                m_occ++;
            end else m_ovf = 1;
        end
        m_ch = (ch == 15) ? 0 : ch + 1;
        if (ch == 15) m_ts++;
    endtask

    // one clock: drive at negedge, check at next negedge
    task automatic cyc(input bit v, input int s, input bit r);
        in_valid = v; in_sample = 10'(s); rd_en = r;
        e_trig = 0;
        e_rd = 0;
        if (v) model_step(s);
        if (r && m_occ > 0 && q_ch.size() > 0) begin
            e_rd = 1;
            e_rch = q_ch.pop_front(); e_rval = q_val.pop_front(); e_rts = q_ts.pop_front();
            m_occ--;
        end
        @(negedge clk);
        check(trig == e_trig, "R4", "trig", trig, e_trig);
        if (e_trig) check(trig_ch == 4'(e_tch), "R4", "trig_ch", trig_ch, e_tch);
        check(overflow == m_ovf, "R10", "overflow", overflow, m_ovf);
        check(rd_valid == e_rd, "R9", "rd_valid", rd_valid, e_rd);
        if (e_rd) begin
            check(rd_ch == 4'(e_rch), "R1", "rd_ch", rd_ch, e_rch);
            check(rd_value == 10'(e_rval), "R5 R6", "rd_value", rd_value, e_rval);
            check(rd_stamp == 28'(e_rts), "R8", "rd_stamp", rd_stamp, e_rts);
        end
    endtask

    task automatic frame(input int base, input int hot_ch, input int hot_val);
        for (int c = 0; c < 16; c++) cyc(1, (c == hot_ch) ? hot_val : base, 0);
    endtask

    task automatic drain(output int got);
        got = 0;
        while (m_occ > 0) begin cyc(0, 0, 1); got++; end
        cyc(0, 0, 1); // read on empty: R9 expects no rd_valid
    endtask

    initial begin
        int got;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) begin
            m_h1[i] = 0; m_h2[i] = 0; m_st[i] = 0; m_age[i] = 0;
            for (int j = 0; j < PRE; j++) m_dly[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check(buf_empty == 1'b1, "R7", "reset empty", buf_empty, 1);
        check(overflow == 1'b0, "R10", "reset overflow", overflow, 0);
        check(trig == 1'b0, "R4", "reset trig", trig, 0);
        check(rd_valid == 1'b0, "R9", "reset rd_valid", rd_valid, 0);

        cfg_thresh = 10'd500; cfg_post = 4'd3;
        // R7 quiet frames, with idle gaps (R1 hold)
        for (int f = 0; f < 3; f++) begin frame(100, -1, 0); cyc(0, 0, 0); end
        check(buf_empty == 1'b1, "R7", "quiet store empty", buf_empty, 1);
        // R2 single spike is rejected by the median
        frame(100, 5, 900);
        frame(100, -1, 0); frame(100, -1, 0);
        check(buf_empty == 1'b1, "R2", "spike stored", buf_empty, 1);
        // R3 filtered value equal to threshold is no hit
        for (int f = 0; f < 3; f++) frame(100, 3, 500);
        frame(100, -1, 0); frame(100, -1, 0);
        check(buf_empty == 1'b1, "R3", "equal threshold stored", buf_empty, 1);
        // R5 R6 two-frame pulse on channel 7: hits in two frames, 2 pre + 3 post
        frame(100, -1, 0);
        frame(100, 7, 800); frame(100, 7, 800);
        for (int f = 0; f < 8; f++) frame(100, -1, 0);
        check(q_ch.size() == 7, "R6", "window length model", q_ch.size(), 7);
        drain(got);
        check(got == 7, "R5 R6", "records for pulse", got, 7);

        // constrained random rounds
        for (int r = 0; r < 8; r++) begin
            int pc1, pc2, len;
            cfg_thresh = 10'(300 + $urandom_range(0, 200));
            cfg_post = POST_W'($urandom_range(0, 6));
            pc1 = $urandom_range(0, 15);
            pc2 = $urandom_range(0, 15);
            len = $urandom_range(1, 4);
            for (int f = 0; f < 16; f++) begin
                for (int c = 0; c < 16; c++) begin
                    int s = 80 + $urandom_range(0, 40);
                    if ((c == pc1 && f >= 3 && f < 3 + len) ||
                        (c == pc2 && f >= 6 && f < 8))
                        s = 600 + $urandom_range(0, 400);
                    if ($urandom_range(0, 7) == 0) cyc(0, 0, 0);
                    cyc(1, s, 0);
                end
            end
            drain(got);
        end

        // R10 overflow: everything above zero is kept
        cfg_thresh = 10'd0; cfg_post = 4'd1;
        for (int f = 0; f < 6; f++) frame(50 + f, -1, 0);
        check(overflow == 1'b1, "R10", "overflow set", overflow, 1);
        drain(got);
        check(got == DEPTH, "R10", "records kept when full", got, DEPTH);
        cyc(0, 0, 0);
        check(overflow == 1'b1, "R10", "overflow sticky", overflow, 1);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule